// File: doc/BRIEF.md
# External pin interrupt sense controller

This block turns activity on eight asynchronous input pins into per-line interrupt requests for a small processor. Each pin passes through a two-stage synchronizer. It is then judged against a two-bit sense mode: a held low level, any change, a falling transition or a rising transition. The transition modes are detected by comparing consecutive synchronized samples, so a pulse held across one clock edge is enough. A detected transition sets a sticky per-pin flag. Low-level mode does not use the flag: its request simply follows the synchronized pin.

A request is presented to the processor only when the pin's enable bit and the global interrupt enable are both one. The block does not care who drives the pin. If the pin is also driven as an output, software can raise its own interrupt by toggling it. Flags are cleared by the per-line acknowledge, or by writing one to the flag's bit through the register port.

Software configures the block through a small register port. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset, every register (both sense-mode registers, the enable register and the flag register) reads 0, and `irq_req_o` is 0.
- R2: Register address 0 holds the sense modes of pins 3..0, and address 1 holds pins 7..4. Pin n's pair sits at bits 2(n mod 4)+1 : 2(n mod 4). Address 2 is the enable register, with bit n for pin n. Address 3 reads the flags. Addresses 0 to 2 are read/write. A write to address 3 leaves addresses 0 to 2 unchanged.
- R3: `pin_sync_o` equals `pin_i` as it stood two clock edges earlier.
- R4: In mode 00, `irq_req_o[n]` is the inverse of `pin_sync_o[n]` while the line is enabled. It is not latched, and the pin sets no flag. A pin change reaches the request after two clock edges.
- R5: Mode 01 sets the flag on any change of the synchronized pin, mode 10 on a 1-to-0 change, and mode 11 on a 0-to-1 change. The flag and the request rise three clock edges after the pin changes. A pulse held for a single clock period is detected.
- R6: A flag stays set until `irq_ack_i[n]` is high at a clock edge, or until a write to address 3 has bit n at one. Writing zero to a bit leaves that flag alone. If a new detection and a clear arrive in the same cycle, the detection wins.
- R7: `irq_req_o[n]` is 0 unless enable bit n and `gie_i` are both 1. Flags still set while the line is masked, and enabling the line afterwards raises the request at once.
- R8: After a pin's sense mode changes, the first cycle under the new mode only takes a reference sample. A synchronized transition seen in that cycle sets no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 8 | Asynchronous external pins |
| gie_i | input | 1 | Global interrupt enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address (0, 1 sense; 2 enable; 3 flags) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for `reg_addr_i` |
| irq_ack_i | input | 8 | Per-line acknowledge, clears the flag |
| pin_sync_o | output | 8 | Synchronized pin values |
| irq_req_o | output | 8 | Per-line interrupt requests |

## Verification
Each result has a fixed latency from the pin change that causes it:
- the synchronized pin appears two edges after the pin changes;
- a level request follows those same two edges;
- an edge or change flag, and its request, appear three edges after the pin changes;
- register writes and acknowledges act on the next edge;
- the enable and global gating act combinationally.

The bench drives inputs and samples outputs just after falling edges. It counts rising edges from each stimulus, and the directed checks sample one edge before and exactly at the due cycle. The random phase compares every cycle against a cycle-stepped model derived from these latencies.

// File: rtl/irq_sense_pkg.sv
// Shared types for the external pin interrupt sense controller.
// Assumes two sense bits per pin and one register port data width.
package irq_sense_pkg;

    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_mode_e;

    // True when the sample pair (older, newer) matches a transition mode.
    function automatic logic sense_hit(sense_mode_e mode, logic older, logic newer);
        case (mode)
            SENSE_ANY:  return older ^ newer;
            SENSE_FALL: return older & ~newer;
            SENSE_RISE: return ~older & newer;
            default:    return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/irq_sync.sv
// Multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes each bit is independent; no bus coherency is implied.
module irq_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Shift the raw inputs through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/irq_pin_sense.sv
// Sense logic for one pin: transition detection, sticky flag, raw request.
// Assumes pin_s is already synchronized. The first cycle after a mode
// change only captures a reference sample.
module irq_pin_sense
    import irq_sense_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pin_s,
    input  sense_mode_e mode_i,
    input  logic        clr_i,
    output logic        flag_o,
    output logic        raw_req_o
);
    logic        prev_q;
    sense_mode_e mode_last_q;
    logic        armed;
    logic        hit;

    assign armed = (mode_i == mode_last_q);
    assign hit   = armed && sense_hit(mode_i, prev_q, pin_s);

    // Keep the previous sample and the mode it was judged under.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q      <= 1'b0;
            mode_last_q <= SENSE_LOW;
        end else begin
            prev_q      <= pin_s;
            mode_last_q <= mode_i;
        end
    end

    // Sticky flag: a detection beats a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else if (hit) begin
            flag_o <= 1'b1;
        end else if (clr_i) begin
            flag_o <= 1'b0;
        end
    end

    assign raw_req_o = (mode_i == SENSE_LOW) ? ~pin_s : flag_o;
endmodule

// File: rtl/ext_irq_sense.sv
// External pin interrupt sense controller top.
// Holds the sense, enable and flag registers behind a simple register port,
// synchronizes the pins and gates each request by its enable and gie_i.
// Assumes software masks a line before changing its sense mode.
module ext_irq_sense
    import irq_sense_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] pin_i,
    input  logic              gie_i,
    input  logic              reg_wr_i,
    input  logic [1:0]        reg_addr_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    input  logic [DATA_W-1:0] irq_ack_i,
    output logic [DATA_W-1:0] pin_sync_o,
    output logic [DATA_W-1:0] irq_req_o
);
    localparam int N_PINS  = DATA_W;
    localparam int PPR     = DATA_W / 2;
    localparam int N_SENSE = N_PINS / PPR;
    localparam logic [1:0] A_MASK = 2'(N_SENSE);
    localparam logic [1:0] A_FLAG = 2'(N_SENSE + 1);

    logic [N_PINS-1:0][1:0] sense_q;
    logic [N_PINS-1:0]      mask_q;
    logic [N_PINS-1:0]      flag_vec;
    logic [N_PINS-1:0]      raw_req;
    logic [N_PINS-1:0]      clr_vec;

    irq_sync #(.WIDTH(N_PINS), .STAGES(SYNC_STAGES)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_i),
        .sync_o  (pin_sync_o)
    );

    // Register writes for the sense modes and the enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sense_q <= '0;
            mask_q  <= '0;
        end else if (reg_wr_i) begin
            for (int r = 0; r < N_SENSE; r++) begin
                if (reg_addr_i == 2'(r)) begin
                    for (int k = 0; k < PPR; k++) begin
                        sense_q[r*PPR+k] <= reg_wdata_i[2*k +: 2];
                    end
                end
            end
            if (reg_addr_i == A_MASK) begin
                mask_q <= reg_wdata_i;
            end
        end
    end

    // Combinational read mux.
    always_comb begin
        reg_rdata_o = '0;
        for (int r = 0; r < N_SENSE; r++) begin
            if (reg_addr_i == 2'(r)) begin
                for (int k = 0; k < PPR; k++) begin
                    reg_rdata_o[2*k +: 2] = sense_q[r*PPR+k];
                end
            end
        end
        if (reg_addr_i == A_MASK) reg_rdata_o = mask_q;
        if (reg_addr_i == A_FLAG) reg_rdata_o = flag_vec;
    end

    // Clear sources: acknowledge or write-one to the flag register.
    assign clr_vec = irq_ack_i | ((reg_wr_i && reg_addr_i == A_FLAG) ? reg_wdata_i : '0);

    for (genvar g = 0; g < N_PINS; g++) begin : g_pin
        irq_pin_sense pin_u (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_s     (pin_sync_o[g]),
            .mode_i    (sense_mode_e'(sense_q[g])),
            .clr_i     (clr_vec[g]),
            .flag_o    (flag_vec[g]),
            .raw_req_o (raw_req[g])
        );
    end

    assign irq_req_o = raw_req & mask_q & {N_PINS{gie_i}};
endmodule

// File: rtl/ext_irq_sense_chk.sv
// Assertion checker for ext_irq_sense, attached by bind.
module ext_irq_sense_chk #(
    parameter int N = 8
) (
    input logic           clk,
    input logic           rst_n,
    input logic           gie_i,
    input logic [N-1:0]   pin_i,
    input logic [N-1:0]   pin_sync_o,
    input logic [N-1:0]   irq_req_o,
    input logic [N-1:0]   mask_q,
    input logic [N-1:0]   flag_vec,
    input logic [N-1:0]   clr_vec,
    input logic [2*N-1:0] sense_flat
);
    logic [1:0] since_rst;

    // Count cycles since reset, saturating, to guard the $past window.
    always_ff @(posedge clk) begin
        if (!rst_n) since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R7: no request without its enable bit and gie_i.
    a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req_o & ~(mask_q & {N{gie_i}})) == '0);

    // R3: synchronized pin is the pin two edges earlier.
    a_r3_sync_delay: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst >= 2'd2) |-> (pin_sync_o == $past(pin_i, 2)));

    for (genvar g = 0; g < N; g++) begin : g_chk
        // R4: level mode request follows the inverted synchronized pin.
        a_r4_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
            (sense_flat[2*g +: 2] == 2'b00 && mask_q[g] && gie_i)
                |-> (irq_req_o[g] == !pin_sync_o[g]));
        // R6: a flag holds unless it is cleared.
        a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_vec[g] && !clr_vec[g]) |=> flag_vec[g]);
        // R5: a flag only rises after a cycle spent in a transition mode.
        a_r5_flag_mode: assert property (@(posedge clk) disable iff (!rst_n)
            (since_rst >= 2'd1 && $rose(flag_vec[g]))
                |-> ($past(sense_flat[2*g +: 2]) != 2'b00));
    end
endmodule

bind ext_irq_sense ext_irq_sense_chk #(.N(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .gie_i      (gie_i),
    .pin_i      (pin_i),
    .pin_sync_o (pin_sync_o),
    .irq_req_o  (irq_req_o),
    .mask_q     (mask_q),
    .flag_vec   (flag_vec),
    .clr_vec    (clr_vec),
    .sense_flat (sense_q)
);

// File: tb/ext_irq_sense_tb_top.sv
// Self-checking bench: directed corner cases plus seeded random traffic
// compared against a cycle-stepped model of the requirements.
module ext_irq_sense_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] pin_i = 8'hFF;
    logic       gie_i = 1'b1;
    logic       reg_wr_i = 1'b0;
    logic [1:0] reg_addr_i = 2'd0;
    logic [7:0] reg_wdata_i = 8'h00;
    logic [7:0] reg_rdata_o;
    logic [7:0] irq_ack_i = 8'h00;
    logic [7:0] pin_sync_o;
    logic [7:0] irq_req_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ext_irq_sense dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .gie_i(gie_i),
        .reg_wr_i(reg_wr_i), .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i),
        .reg_rdata_o(reg_rdata_o), .irq_ack_i(irq_ack_i),
        .pin_sync_o(pin_sync_o), .irq_req_o(irq_req_o)
    );

    // Model state, stepped at each rising edge.
    logic [7:0] m_s1, m_s2, m_prev, m_flag, m_mask, m_nf;
    logic [7:0][1:0] m_sense, m_last;

    function automatic logic hit_fn(logic [1:0] md, logic p, logic c);
        case (md)
            2'b01:   return p ^ c;
            2'b10:   return p & ~c;
            2'b11:   return ~p & c;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [7:0] exp_req();
        logic [7:0] r;
        for (int n = 0; n < 8; n++)
            r[n] = m_mask[n] & gie_i & ((m_sense[n] == 2'b00) ? ~m_s2[n] : m_flag[n]);
        return r;
    endfunction

    function automatic logic [7:0] exp_rdata(logic [1:0] a);
        logic [7:0] r;
        r = '0;
        case (a)
            2'd0: for (int k = 0; k < 4; k++) r[2*k +: 2] = m_sense[k];
            2'd1: for (int k = 0; k < 4; k++) r[2*k +: 2] = m_sense[4+k];
            2'd2: r = m_mask;
            default: r = m_flag;
        endcase
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_prev = '0; m_flag = '0; m_mask = '0;
            m_sense = '0; m_last = '0;
        end else begin
            for (int n = 0; n < 8; n++) begin
                if ((m_sense[n] == m_last[n]) && hit_fn(m_sense[n], m_prev[n], m_s2[n]))
                    m_nf[n] = 1'b1;
                else if (irq_ack_i[n] || (reg_wr_i && reg_addr_i == 2'd3 && reg_wdata_i[n]))
                    m_nf[n] = 1'b0;
                else
                    m_nf[n] = m_flag[n];
            end
            m_flag = m_nf;
            m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_i;
            m_last = m_sense;
            if (reg_wr_i) begin
                if (reg_addr_i == 2'd0) for (int k = 0; k < 4; k++) m_sense[k] = reg_wdata_i[2*k +: 2];
                if (reg_addr_i == 2'd1) for (int k = 0; k < 4; k++) m_sense[4+k] = reg_wdata_i[2*k +: 2];
                if (reg_addr_i == 2'd2) m_mask = reg_wdata_i;
            end
        end
    end

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
        step();
        reg_wr_i = 1'b0;
    endtask

    task automatic rd_check(string tag, logic [1:0] a, logic [7:0] exp);
        reg_addr_i = a;
        #1;
        check(tag, reg_rdata_o, exp);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        step(3);
        rst_n = 1'b1;
        step();
        // R1: reset state.
        check("R1 req", irq_req_o, 8'h00);
        for (int a = 0; a < 4; a++) rd_check("R1 reg", 2'(a), 8'h00);
        step(3);

        // R2: register map read/write; the flag write leaves the others alone.
        wr(2'd0, 8'h1B); wr(2'd1, 8'hE4); wr(2'd2, 8'h5A); wr(2'd3, 8'hFF);
        rd_check("R2 sense lo", 2'd0, 8'h1B);
        rd_check("R2 sense hi", 2'd1, 8'hE4);
        rd_check("R2 mask", 2'd2, 8'h5A);
        wr(2'd0, 8'h00); wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd3, 8'hFF);
        step(2);

        // R3: two-edge synchronizer delay.
        pin_i = 8'h0F;
        step(); check("R3 sync early", pin_sync_o, 8'hFF);
        step(); check("R3 sync due", pin_sync_o, 8'h0F);
        pin_i = 8'hFF; step(3);

        // R4: low level follows the pin, not latched, no flag.
        wr(2'd2, 8'hFF);
        check("R4 idle high", irq_req_o, 8'h00);
        pin_i = 8'hF7;
        step(); check("R4 early", irq_req_o, 8'h00);
        step(); check("R4 low level", irq_req_o, 8'h08);
        rd_check("R4 no flag", 2'd3, 8'h00);
        pin_i = 8'hFF; step(2);
        check("R4 not latched", irq_req_o, 8'h00);

        // R5: one-clock rising pulse on pin 5 (upper reg bits 3:2 = 11).
        wr(2'd2, 8'h20); wr(2'd1, 8'h0C);
        pin_i = 8'hDF; step(4);
        rd_check("R5 fall ignored in rise", 2'd3, 8'h00);
        pin_i = 8'hFF; step();
        pin_i = 8'hDF; step();
        check("R5 pulse early", irq_req_o, 8'h00);
        step();
        check("R5 pulse req", irq_req_o, 8'h20);
        rd_check("R5 pulse flag", 2'd3, 8'h20);
        irq_ack_i = 8'h20; step(); irq_ack_i = 8'h00;
        check("R6 ack clears", irq_req_o, 8'h00);

        // R5: falling edge on pin 1 (lower reg bits 3:2 = 10).
        wr(2'd2, 8'h02); wr(2'd0, 8'h08); step(2);
        pin_i = 8'hDD; step(3);
        check("R5 fall req", irq_req_o, 8'h02);
        wr(2'd3, 8'h00);
        rd_check("R6 write zero keeps", 2'd3, 8'h02);
        wr(2'd3, 8'h02);
        rd_check("R6 write one clears", 2'd3, 8'h00);

        // R5 any change on pin 6 both directions; R7 masked flag then enable.
        wr(2'd2, 8'h00); wr(2'd1, 8'h1C); step(2);
        pin_i = 8'h9D; step(3);
        rd_check("R5 change 1to0", 2'd3, 8'h40);
        check("R7 masked", irq_req_o, 8'h00);
        wr(2'd2, 8'h40);
        check("R7 enable raises", irq_req_o, 8'h40);
        gie_i = 1'b0; #1;
        check("R7 gie off", irq_req_o, 8'h00);
        gie_i = 1'b1;
        wr(2'd3, 8'h40);
        pin_i = 8'hDD; step(3);
        rd_check("R5 change 0to1", 2'd3, 8'h40);
        wr(2'd3, 8'h40);

        // R8: transition seen in the first cycle of a new mode is ignored.
        wr(2'd2, 8'h01);
        pin_i = 8'hDC; step();
        wr(2'd0, 8'h0A);
        step();
        rd_check("R8 arm flag", 2'd3, 8'h00);
        check("R8 arm req", irq_req_o, 8'h00);
        pin_i = 8'hDD; step(3);
        pin_i = 8'hDC; step(3);
        rd_check("R8 later fall", 2'd3, 8'h01);

        // Random phase against the model.
        void'($urandom(32'h1234_5678));
        for (int c = 0; c < 3000; c++) begin
            check("R7 random req", irq_req_o, exp_req());
            check("R2 random rdata", reg_rdata_o, exp_rdata(reg_addr_i));
            pin_i       = pin_i ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
            reg_wr_i    = ($urandom % 6) == 0;
            reg_addr_i  = 2'($urandom);
            reg_wdata_i = 8'($urandom);
            irq_ack_i   = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
            if (($urandom % 16) == 0) gie_i = ~gie_i;
            step();
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule